// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block produces the clock-enable tick that drives slow timekeeping logic. The tick comes from one of two sources. The first is an internal RC strobe, which goes through a divider programmed by software. The second is an external crystal strobe, which is passed through without division. Both sources arrive as single-cycle enable strobes in the system clock domain. The output tick is a registered single-cycle pulse in the same domain.

Software reaches the block through a simple 32-bit register port with a write strobe and a combinational read path. The source-select register is guarded by a 16-bit unlock pattern, which must appear in the upper half of every write to it. The divider register needs no key. A change of source is held as a request. It becomes the active source only in a cycle where the source currently in use completes a tick. As a result, the output never shows a clipped interval or a doubled pulse around a switch.

Top module: `lsclk_select`

## Requirements
- R1: After reset the internal source is active, the divider value is 0, every register reads 0 and the tick output is low.
- R2: A write to offset 0x00 changes the source request only when write data bits 31:16 equal 0x16AA. Any other write there leaves the request unchanged, and the active source and the tick train continue as before.
- R3: Reading offset 0x00 returns the active source in bit 0 (0 for internal, 1 for external) and zeros in bits 31:1. The unlock pattern is never stored or returned.
- R4: Offset 0x08 holds the divider value P in bits 4:0. It is written without a key, bits 31:5 of the write are ignored, and it reads back in bits 4:0 with zeros above.
- R5: While the internal source is active, the tick output pulses for exactly one cycle after every (P+1)-th internal strobe. Gaps between strobes do not change the count.
- R6: While the external source is active, the tick output pulses in the cycle after each external strobe. Internal strobes and P have no effect on the tick.
- R7: A pending source request becomes active only in the cycle where the currently active source completes a tick. Until then, the strobes of the requested source produce no ticks and offset 0x00 reads the old source.
- R8: After a switch to the internal source, the divider starts from zero, so the first internal tick comes after exactly P+1 internal strobes.
- R9: When a keyed write lands in the same cycle as a completed tick, that tick still uses the previous request. The new request waits for the following tick.
- R10: Offsets other than 0x00 and 0x08 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| int_stb | input | 1 | Internal RC oscillator strobe |
| ext_stb | input | 1 | External crystal strobe |
| tick_o | output | 1 | Low-speed clock-enable tick |
| src_o | output | 1 | Active source (1 means external) |

## Verification
Two events can fall in the same cycle: a keyed source-select write, and the strobe that completes the active source's tick. The bench provokes this by presenting the keyed write together with the final internal strobe of a count. It then checks three things: that the tick appears, that offset 0x00 still reads the old source, and that the switch happens only at the next full divided interval. A near-exhaustive sweep over all 32 divider values, with both dense and sparse strobe patterns, measures each inter-tick gap against P+1 computed in the bench.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
    localparam int unsigned KEY_W     = 16;
    localparam logic [KEY_W-1:0] UNLOCK_PATTERN = 16'h16AA;
    localparam int unsigned CTRL_OFS  = 8'h00;
    localparam int unsigned PRE_OFS   = 8'h08;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;
endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
    import lsclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  src_e              active_src,
    output src_e              sel_req,
    output logic [PRE_W-1:0]  pre_val,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned KEY_LSB = DATA_W - KEY_W;

    typedef struct packed {
        src_e             req;
        logic [PRE_W-1:0] pre;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  key_ok;

    assign key_ok = (wr_data[DATA_W-1:KEY_LSB] == UNLOCK_PATTERN);

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(CTRL_OFS) && key_ok) begin
                regs_d.req = src_e'(wr_data[0]);
            end
            if (wr_addr == ADDR_W'(PRE_OFS)) begin
                regs_d.pre = wr_data[PRE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{req: SRC_INT, pre: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_OFS)) begin
            rd_data[0] = active_src;
        end else if (rd_addr == ADDR_W'(PRE_OFS)) begin
            rd_data[PRE_W-1:0] = regs_q.pre;
        end
    end

    assign sel_req = regs_q.req;
    assign pre_val = regs_q.pre;
endmodule

// File: rtl/lsclk_div.sv
module lsclk_div #(
    parameter int unsigned PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stb,
    input  logic [PRE_W-1:0] limit,
    output logic             hit
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        hit   = 1'b0;
        if (!run) begin
            div_d.cnt = '0;
        end else if (stb) begin
            if (div_q.cnt >= limit) begin
                hit       = 1'b1;
                div_d.cnt = '0;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '{cnt: '0};
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/lsclk_switch.sv
module lsclk_switch
    import lsclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  src_e req,
    input  logic int_hit,
    input  logic ext_stb,
    output src_e active,
    output logic tick
);
    typedef struct packed {
        src_e active;
        logic tick;
    } sw_t;

    sw_t  sw_d, sw_q;
    logic boundary;

    always_comb begin
        sw_d     = sw_q;
        boundary = (sw_q.active == SRC_EXT) ? ext_stb : int_hit;
        sw_d.tick = boundary;
        if (boundary) begin
            sw_d.active = req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '{active: SRC_INT, tick: 1'b0};
        end else begin
            sw_q <= sw_d;
        end
    end

    assign active = sw_q.active;
    assign tick   = sw_q.tick;
endmodule

// File: rtl/lsclk_select.sv
module lsclk_select
    import lsclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              int_stb,
    input  logic              ext_stb,
    output logic              tick_o,
    output logic              src_o
);
    src_e             sel_req;
    src_e             active;
    logic [PRE_W-1:0] pre_val;
    logic             int_hit;
    logic             div_run;

    assign div_run = (active == SRC_INT);

    lsclk_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PRE_W  (PRE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .active_src (active),
        .sel_req    (sel_req),
        .pre_val    (pre_val),
        .rd_data    (rd_data)
    );

    lsclk_div #(
        .PRE_W (PRE_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .stb   (int_stb),
        .limit (pre_val),
        .hit   (int_hit)
    );

    lsclk_switch u_switch (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (sel_req),
        .int_hit (int_hit),
        .ext_stb (ext_stb),
        .active  (active),
        .tick    (tick_o)
    );

    assign src_o = active;
endmodule

// File: rtl/lsclk_select_chk.sv
module lsclk_select_chk
    import lsclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              int_stb,
    input logic              ext_stb,
    input logic              tick_o,
    input logic              src_o,
    input logic              sel_req
);
    AST_TICK_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(src_o ? ext_stb : int_stb)); // R5

    AST_SWITCH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_o) |-> tick_o); // R7

    AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o && !ext_stb) |=> !tick_o); // R6

    AST_BAD_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_OFS) && wr_data[DATA_W-1:DATA_W-KEY_W] != UNLOCK_PATTERN)
        |=> $stable(sel_req)); // R2

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(CTRL_OFS)) |-> (rd_data[DATA_W-1:1] == '0 && rd_data[0] == src_o)); // R3
endmodule

bind lsclk_select lsclk_select_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .int_stb (int_stb),
    .ext_stb (ext_stb),
    .tick_o  (tick_o),
    .src_o   (src_o),
    .sel_req (sel_req)
);

// File: tb/lsclk_select_tb_top.sv
module lsclk_select_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        int_stb = 1'b0;
    logic        ext_stb = 1'b0;
    logic        tick_o;
    logic        src_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lsclk_select dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .int_stb (int_stb),
        .ext_stb (ext_stb),
        .tick_o  (tick_o),
        .src_o   (src_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive strobes for one cycle; on return tick_o shows that cycle's result.
    task automatic step(input logic ib, input logic eb);
        int_stb = ib;
        ext_stb = eb;
        @(posedge clk);
        @(negedge clk);
        int_stb = 1'b0;
        ext_stb = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic ib, input logic eb);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step(ib, eb);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic sync_int();
        for (int i = 0; i < 64; i++) begin
            step(1'b1, 1'b0);
            if (tick_o) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tick", {31'b0, tick_o}, 0);
        check("R1 src", {31'b0, src_o}, 0);
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h08, v); check("R1 pre", v, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 unmapped offsets
        wr(8'h04, 32'h16AA_FFFF, 1'b0, 1'b0);
        wr(8'h0C, 32'hFFFF_FFFF, 1'b0, 1'b0);
        rd(8'h04, v); check("R10 rd04", v, 0);
        rd(8'h0C, v); check("R10 rd0c", v, 0);
        rd(8'h08, v); check("R10 pre untouched", v, 0);
        rd(8'h00, v); check("R10 ctrl untouched", v, 0);

        // R4 + R5 sweep over every divider value, dense and sparse strobes
        for (int p = 0; p < 32; p++) begin
            wr(8'h08, 32'hFFFF_FFE0 | p, 1'b0, 1'b0);
            rd(8'h08, v); check("R4 pre readback", v, p);
            for (int pat = 0; pat < 2; pat++) begin
                sync_int();
                for (int k = 0; k < 2; k++) begin
                    n = 0;
                    for (int i = 0; i < 40; i++) begin
                        if (pat == 1) begin
                            step(1'b0, 1'b0);
                            if (tick_o) n = 100;
                        end
                        step(1'b1, 1'b0);
                        n++;
                        if (tick_o) break;
                    end
                    check("R5 gap", n, p + 1);
                end
            end
        end

        // R2 bad keys with P=3, aligned at boundary
        wr(8'h08, 32'd3, 1'b0, 1'b0);
        sync_int();
        wr(8'h00, 32'h16AB_0001, 1'b0, 1'b0);
        wr(8'h00, 32'h0000_0001, 1'b0, 1'b0);
        step(1'b0, 1'b1); check("R2 ext ignored", {31'b0, tick_o}, 0);
        n = 0;
        for (int i = 0; i < 4; i++) begin step(1'b1, 1'b0); n += tick_o; end
        check("R2 int ticks", n, 1);
        rd(8'h00, v); check("R2 ctrl kept", v, 0);

        // R7 keyed write, pending until internal boundary
        wr(8'h00, 32'h16AA_0001, 1'b0, 1'b0);
        rd(8'h00, v); check("R7 pending", v, 0);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b1); check("R7 ext before switch", {31'b0, tick_o}, 0);
        rd(8'h00, v); check("R7 still int", v, 0);
        step(1'b1, 1'b0); check("R7 no early tick", {31'b0, tick_o}, 0);
        step(1'b1, 1'b0); check("R7 boundary tick", {31'b0, tick_o}, 1);
        rd(8'h00, v); check("R3 ctrl reads ext only", v, 1);
        check("R3 src_o", {31'b0, src_o}, 1);

        // R6 external bypass
        for (int j = 0; j < 24; j++) begin
            step(1'b1, (j % 3) != 0);
            check("R6 ext tick", {31'b0, tick_o}, {31'b0, ((j % 3) != 0)});
        end

        // R8 back to internal, divider restarts
        wr(8'h00, 32'h16AA_0000, 1'b1, 1'b0);
        rd(8'h00, v); check("R8 pending ext", v, 1);
        step(1'b1, 1'b0); check("R8 int no tick", {31'b0, tick_o}, 0);
        step(1'b0, 1'b1); check("R8 ext boundary", {31'b0, tick_o}, 1);
        rd(8'h00, v); check("R8 now int", v, 0);
        n = 0;
        for (int i = 0; i < 10; i++) begin step(1'b1, 1'b0); n++; if (tick_o) break; end
        check("R8 first gap", n, 4);

        // R9 keyed write coinciding with completed tick
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        wr(8'h00, 32'h16AA_0001, 1'b1, 1'b0);
        check("R9 tick", {31'b0, tick_o}, 1);
        rd(8'h00, v); check("R9 old src", v, 0);
        n = 0;
        for (int i = 0; i < 10; i++) begin step(1'b1, 1'b0); n++; if (tick_o) break; end
        check("R9 next gap", n, 4);
        rd(8'h00, v); check("R9 switched", v, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule